// File: doc/BRIEF.md
# Converter Reset and Power-Down Sequencer

This block decides when the digital section of a data converter may produce valid samples. It runs on the system clock and combines an active-high power-good flag, which stands in for the supply monitor, with an active-low external reset pin. After power is good, it waits until the system clock has been seen running for a number of cycles. It then runs an initialization window of fixed length, and only after that does it release the data output.

The reset pin does two jobs, told apart by how long it stays low. A short low pulse ends in a fresh initialization window once the pin returns high. A low held long enough moves the block into power-down, where the internal clock enable drops. Throughout, a force-low output keeps the serial data line at zero whenever the converter is not delivering valid data.

The pin is brought into the clock domain through two flip-flops. One counter is shared by the clock-detect wait, the initialization window and the low-time measurement.

Top module: `conv_reset_seq`

## Requirements
- R1: While `pwr_good` is low, the block is held in reset asynchronously with `force_low`=1, `clk_en`=0 and `pdown`=0.
- R2: After `pwr_good` rises, the block waits DETECT_CYCLES (16) rising clock edges with `force_low`=1 and `clk_en`=0. At the 16th edge it leaves the wait.
- R3: Initialization lasts exactly INIT_CYCLES (1024) clock cycles with `force_low`=1 and `clk_en`=1. After that, `force_low` drops to 0.
- R4: In normal operation `force_low`=0, `clk_en`=1 and `pdown`=0, and this holds while the synchronized pin stays high.
- R5: The reset pin passes through two synchronizing flip-flops. A level applied before edge k first changes the state at edge k+2. A low that covers a single rising edge is still captured.
- R6: A low pulse shorter than the power-down threshold raises `force_low` and starts a complete new initialization window when the pin returns high.
- R7: A low pulse that arrives during initialization restarts the window from its beginning.
- R8: When the synchronized pin has been low for PDOWN_CYCLES (65,536) consecutive cycles, the block enters power-down with `pdown`=1, `clk_en`=0 and `force_low`=1. A shorter low time never sets `pdown`.
- R9: In power-down, a high synchronized pin starts a full initialization window, which is followed by normal operation.
- R10: Dropping `pwr_good` at any time returns the block to the reset outputs of R1 without waiting for a clock edge.
- R11: If the synchronized pin is low when the clock-detect wait ends, the block goes straight into low-time measurement with `clk_en`=1 and `force_low`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power-on flag, active high; low acts as asynchronous reset |
| rst_pin_n | input | 1 | External reset / power-down pin, active low, asynchronous to `clk` |
| force_low | output | 1 | Forces the serial data output to zero when high |
| clk_en | output | 1 | Enable for the internal digital clocks |
| pdown | output | 1 | High while in power-down |

## Verification
The bound checker checks on every cycle the rules that follow from a single step of the state machine: the outputs in the wait and power-down states, a low pin leaving normal operation, a high pin leaving power-down, and `force_low` falling only at the last initialization cycle. Only the bench scenarios can show the long-range timing. This covers the 1024-cycle window counted from a pulse, the exact 65,536-cycle threshold against a hold just short of it, the restart of an interrupted window, and the two-edge pin latency. For these, a behavioural reference model is compared with the ports on every clock.

// File: rtl/conv_reset_seq.sv
module conv_reset_seq #(
  parameter int INIT_CYCLES   = 1024,
  parameter int PDOWN_CYCLES  = 65536,
  parameter int DETECT_CYCLES = 16
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic rst_pin_n,
  output logic force_low,
  output logic clk_en,
  output logic pdown
);

  localparam int MAXC_A = (INIT_CYCLES > PDOWN_CYCLES) ? INIT_CYCLES : PDOWN_CYCLES;
  localparam int MAXC   = (MAXC_A > DETECT_CYCLES) ? MAXC_A : DETECT_CYCLES;
  localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

  localparam logic [2:0] S_WAIT = 3'd0;
  localparam logic [2:0] S_INIT = 3'd1;
  localparam logic [2:0] S_RUN  = 3'd2;
  localparam logic [2:0] S_LOW  = 3'd3;
  localparam logic [2:0] S_PDN  = 3'd4;

  logic [1:0]    sync;
  logic          pin_s;
  logic [2:0]    state, nxt;
  logic [CW-1:0] cnt;

  assign pin_s = sync[1];

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) sync <= '0;
    else           sync <= {sync[0], rst_pin_n};

  always_comb begin
    nxt = state;
    case (state)
      S_WAIT: if (cnt == CW'(DETECT_CYCLES - 1)) nxt = pin_s ? S_INIT : S_LOW;
      S_INIT: if (!pin_s) nxt = S_LOW;
              else if (cnt == CW'(INIT_CYCLES - 1)) nxt = S_RUN;
      S_RUN:  if (!pin_s) nxt = S_LOW;
      S_LOW:  if (pin_s) nxt = S_INIT;
              else if (cnt == CW'(PDOWN_CYCLES - 1)) nxt = S_PDN;
      S_PDN:  if (pin_s) nxt = S_INIT;
      default: nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)
        cnt <= '0;
      else if (state == S_WAIT || state == S_INIT || state == S_LOW)
        cnt <= cnt + 1'b1;
    end

  assign force_low = (state != S_RUN);
  assign clk_en    = (state != S_WAIT) && (state != S_PDN);
  assign pdown     = (state == S_PDN);

endmodule

module conv_reset_seq_chk #(
  parameter int INIT_CYCLES = 1024,
  parameter int CW          = 16
) (
  input logic          clk,
  input logic          pwr_good,
  input logic          pin_s,
  input logic [2:0]    state,
  input logic [CW-1:0] cnt,
  input logic          force_low,
  input logic          clk_en,
  input logic          pdown
);

  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == 3'd0) |-> (force_low && !clk_en && !pdown));

  a_r8_pdown_outputs: assert property (@(posedge clk) disable iff (!pwr_good)
    pdown |-> (force_low && !clk_en));

  a_r8_pdown_entry: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(pdown) |-> ($past(state) == 3'd3));

  a_r6_low_leaves_run: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == 3'd2 && !pin_s) |=> (state == 3'd3 && force_low));

  a_r9_pdown_exit: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == 3'd4 && pin_s) |=> (state == 3'd1 && !pdown));

  a_r3_release_at_end: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(force_low) |-> ($past(state) == 3'd1 && $past(cnt) == CW'(INIT_CYCLES - 1)));

  a_r4_run_stable: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == 3'd2 && pin_s) |=> !force_low);

endmodule

bind conv_reset_seq conv_reset_seq_chk #(.INIT_CYCLES(INIT_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .pin_s(pin_s), .state(state), .cnt(cnt),
  .force_low(force_low), .clk_en(clk_en), .pdown(pdown)
);

// File: tb/conv_reset_seq_tb.sv
module conv_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_N = 1024;
  localparam int PD_N   = 65536;
  localparam int DET_N  = 16;

  logic clk = 1'b0;
  logic pwr_good = 1'b1;
  logic rst_pin_n = 1'b1;
  logic force_low, clk_en, pdown;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_reset_seq u_dut (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n),
    .force_low(force_low), .clk_en(clk_en), .pdown(pdown)
  );

  // Reference model: 0 wait, 1 init, 2 run, 3 low-time, 4 power-down
  int m_st = 0;
  int m_n  = 0;
  bit m_p1 = 1'b0;
  bit m_p2 = 1'b0;

  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      m_st = 0; m_n = 0; m_p1 = 1'b0; m_p2 = 1'b0;
    end else begin
      bit seen;
      int prev;
      seen = m_p2; m_p2 = m_p1; m_p1 = rst_pin_n;
      prev = m_st;
      if (m_st == 0) begin
        if (m_n == DET_N - 1) m_st = seen ? 1 : 3;
      end else if (m_st == 1) begin
        if (!seen) m_st = 3; else if (m_n == INIT_N - 1) m_st = 2;
      end else if (m_st == 2) begin
        if (!seen) m_st = 3;
      end else if (m_st == 3) begin
        if (seen) m_st = 1; else if (m_n == PD_N - 1) m_st = 4;
      end else if (m_st == 4) begin
        if (seen) m_st = 1;
      end
      m_n = (m_st != prev) ? 0 : m_n + 1;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {force_low,clk_en,pdown} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done)
    chk({tag_of(m_st), " model"}, {force_low, clk_en, pdown},
        {m_st != 2, (m_st != 0 && m_st != 4), m_st == 4});

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic outs(input string tag, input logic [2:0] exp);
    chk(tag, {force_low, clk_en, pdown}, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    #1 pwr_good = 1'b0;
    #1 cmp_on = 1'b1;
    tick(3);
    outs("R1 reset", 3'b100);

    @(negedge clk) pwr_good = 1'b1;
    tick(15);  outs("R2 still waiting", 3'b100);
    tick(1);   outs("R2 wait over, R3 init", 3'b110);
    tick(1023); outs("R3 last init cycle", 3'b110);
    tick(1);   outs("R3 released", 3'b010);
    tick(50);  outs("R4 running", 3'b010);

    rst_pin_n = 1'b0; tick(1); rst_pin_n = 1'b1;
    tick(1);   outs("R5 two-flop latency", 3'b010);
    tick(1);   outs("R6 pulse seen", 3'b110);
    tick(1024); outs("R6 reinit still low", 3'b110);
    tick(1);   outs("R6 reinit done", 3'b010);

    rst_pin_n = 1'b0; tick(1); rst_pin_n = 1'b1;
    tick(500);
    rst_pin_n = 1'b0; tick(1); rst_pin_n = 1'b1;
    tick(1026); outs("R7 restarted window low", 3'b110);
    tick(1);   outs("R7 restarted window done", 3'b010);

    rst_pin_n = 1'b0;
    tick(65538); outs("R8 one short of threshold", 3'b110);
    tick(1);   outs("R8 power-down", 3'b101);
    tick(100); outs("R8 stays down", 3'b101);

    rst_pin_n = 1'b1;
    tick(2);   outs("R9 still down", 3'b101);
    tick(1);   outs("R9 init from power-down", 3'b110);
    tick(1023); outs("R9 init last cycle", 3'b110);
    tick(1);   outs("R9 running", 3'b010);

    @(negedge clk); #(CLK_PERIOD/4) pwr_good = 1'b0;
    #1 outs("R10 async drop", 3'b100);
    tick(3);

    rst_pin_n = 1'b0;
    @(negedge clk) pwr_good = 1'b1;
    tick(15);  outs("R11 waiting", 3'b100);
    tick(1);   outs("R11 low-time after wait", 3'b110);
    tick(65000); outs("R8 long hold below threshold", 3'b110);
    rst_pin_n = 1'b1;
    tick(1026); outs("R11 init after release", 3'b110);
    tick(1);   outs("R11 running", 3'b010);
    tick(5);
    finish_run();
  end
endmodule